// File: doc/BRIEF.md
# VCO Sub-Band Trim Calibrator

This block picks the capacitor-bank trim word of a multi-band oscillator before its phase-locked loop is closed. A start pulse holds the loop open, loads a mid-scale trim, latches the requested division factor (an integer part and a fractional part) and turns it into an expected edge count. Each search round waits a fixed settle time. It then counts rising edges of the divided oscillator clock over a window of system-clock cycles and compares the count with the expected value.

The search bisects the trim range. It keeps a low bound, a high bound and the current trim. A count above the band means the oscillator runs fast, so the search moves to the upper half. A count below the band moves it to the lower half. A count inside the tolerance band ends the search at once. The search never runs more than seven rounds. When it ends, the block releases the loop to closed-loop control, raises a done flag and holds the trim until the next start.

Top module: `vco_trim_cal`

## Requirements
- R1: While reset is high and after it is released, trim is 127, done is 0 and open_loop is 0.
- R2: In the cycle after an accepted start (start high while no calibration runs), open_loop is 1, done is 0 and trim is 127.
- R3: The expected count is floor(TGT_MUL × (div_int + div_frac / 2^FW)). It is latched when start is accepted, so changing the inputs during a run has no effect on that run.
- R4: When the edge count exceeds expected + TOL, the next trim is (trim + 1 + high) / 2, rounded down, and the low bound becomes trim + 1.
- R5: When the edge count is below expected − TOL, the next trim is (low + trim − 1) / 2, rounded down, and the high bound becomes trim − 1.
- R6: When the edge count lies within ±TOL of the expected value, the search stops in that round and keeps the current trim. A difference of exactly TOL counts as inside the band.
- R7: For div_int = 19, div_frac = 25 (FW = 8), with an oscillator whose count falls by 2 per trim step and equals 305 at trim 181, the trim takes the values 127, 191, 159, 175, 183, 179, 181 in that order.
- R8: A run lasts at most 7 rounds. An oscillator that is always too slow ends at trim 0, and one that is always too fast ends at trim 254, each after 7 rounds.
- R9: On completion done is 1 and open_loop is 0. Without a new start, done and trim stay unchanged, even when div_int and div_frac change.
- R10: A start pulse during a running calibration is ignored. The result and the duration of that run are unchanged.
- R11: Each round takes SETTLE + WINDOW + 1 system cycles. The trim changes only at the end of a round. Done rises exactly rounds × (SETTLE + WINDOW + 1) cycles after the accepted start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration when no calibration runs |
| vco_div_clk | input | 1 | Divided oscillator clock, asynchronous to clk |
| div_int | input | NI_W | Integer part of the requested division factor |
| div_frac | input | FW | Fractional part of the requested division factor |
| trim | output | TRIM_W | Capacitor-bank trim word |
| open_loop | output | 1 | High while the loop must stay open for calibration |
| done | output | 1 | Calibration finished; trim is final |

## Verification
The bench models the oscillator as a phase accumulator stepped once per system cycle. This makes any window of WINDOW cycles hold an exact edge count of 667 − 2·trim. Division factors are chosen for several cases:
- targets that stop the search in the first round, in the third round and in the seventh round, some of them exactly one count from the band edge;
- one fraction whose floor and rounded values fall on opposite sides of the band;
- targets beyond the oscillator range in each direction, which force the search to trim 0 or trim 254.

Together these cases separate a wrong comparison direction, a wrong band width, a rounded target, an off-by-one in the bisection and a missing round limit. Timing of every trim change and of done exposes a wrong window or settle length. A second start and a changed division factor during a run show whether the target is latched and the run protected.

// File: rtl/vcal_pkg.sv
package vcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_MEAS,
        ST_DECIDE,
        ST_DONE
    } cal_state_e;

    typedef enum logic [1:0] {
        V_BAND,
        V_FAST,
        V_SLOW
    } verdict_e;

    // Expected edge count: floor(mul * fixed_ratio / 2^fw)
    function automatic logic [31:0] scaled_target(input logic [31:0] fixed_ratio,
                                                  input logic [31:0] mul,
                                                  input int unsigned fw);
        logic [31:0] prod;
        prod = fixed_ratio * mul;
        return prod >> fw;
    endfunction

    function automatic verdict_e judge(input logic [31:0] cnt,
                                       input logic [31:0] tgt,
                                       input logic [31:0] tol);
        if (cnt > tgt + tol) return V_FAST;
        if (cnt + tol < tgt) return V_SLOW;
        return V_BAND;
    endfunction

endpackage

// File: rtl/vcal_edge_sync.sv
module vcal_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/vcal_window_meter.sv
module vcal_window_meter #(
    parameter int WINDOW = 1536,
    parameter int CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  logic             pulse,
    output logic [CNT_W-1:0] edges,
    output logic             last
);
    logic [CNT_W-1:0] ref_q;
    logic [CNT_W-1:0] edges_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ref_q   <= '0;
            edges_q <= '0;
        end else if (run) begin
            ref_q <= ref_q + CNT_W'(1);
            if (pulse) edges_q <= edges_q + CNT_W'(1);
        end
    end

    assign edges = edges_q;
    assign last  = run && (ref_q == CNT_W'(WINDOW - 1));
endmodule

// File: rtl/vcal_bisect.sv
module vcal_bisect #(
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              step,
    input  logic              go_up,
    output logic [TRIM_W-1:0] cur,
    output logic [TRIM_W-1:0] lo,
    output logic [TRIM_W-1:0] hi
);
    localparam logic [TRIM_W-1:0] MID = {1'b0, {(TRIM_W-1){1'b1}}};
    localparam logic [TRIM_W:0]   ONE = {{TRIM_W{1'b0}}, 1'b1};

    logic [TRIM_W-1:0] cur_q, lo_q, hi_q;
    logic [TRIM_W:0]   sum_up, sum_dn;

    assign sum_up = {1'b0, cur_q} + {1'b0, hi_q} + ONE;
    assign sum_dn = {1'b0, lo_q} + {1'b0, cur_q} - ONE;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            lo_q  <= '0;
            hi_q  <= '1;
            cur_q <= MID;
        end else if (step) begin
            if (go_up) begin
                lo_q  <= cur_q + TRIM_W'(1);
                cur_q <= sum_up[TRIM_W:1];
            end else begin
                hi_q  <= cur_q - TRIM_W'(1);
                cur_q <= sum_dn[TRIM_W:1];
            end
        end
    end

    assign cur = cur_q;
    assign lo  = lo_q;
    assign hi  = hi_q;
endmodule

// File: rtl/vco_trim_cal.sv
module vco_trim_cal
    import vcal_pkg::*;
#(
    parameter int TRIM_W      = 8,
    parameter int NI_W        = 6,
    parameter int FW          = 8,
    parameter int WINDOW      = 1536,
    parameter int SETTLE      = 24,
    parameter int TGT_MUL     = 16,
    parameter int TOL         = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              vco_div_clk,
    input  logic [NI_W-1:0]   div_int,
    input  logic [FW-1:0]     div_frac,
    output logic [TRIM_W-1:0] trim,
    output logic              open_loop,
    output logic              done
);
    localparam int CNT_W  = $clog2(WINDOW + 1);
    localparam int ROUNDS = TRIM_W - 1;
    localparam int RND_W  = $clog2(ROUNDS);
    localparam int SET_W  = $clog2(SETTLE + 1);
    localparam int TGT_W  = NI_W + $clog2(TGT_MUL) + 1;

    cal_state_e        st_q;
    logic [SET_W-1:0]  settle_q;
    logic [RND_W-1:0]  round_q;
    logic [TGT_W-1:0]  tgt_q;
    logic              accept, in_decide, last_round;
    logic              rise, win_last;
    logic [CNT_W-1:0]  edges;
    verdict_e          verdict;
    logic [TRIM_W-1:0] cur_w, lo_w, hi_w;
    logic [31:0]       tgt_full;

    assign accept     = start && (st_q == ST_IDLE || st_q == ST_DONE);
    assign in_decide  = (st_q == ST_DECIDE);
    assign last_round = (round_q == RND_W'(ROUNDS - 1));
    assign tgt_full   = scaled_target(32'({div_int, div_frac}), 32'(TGT_MUL), FW);
    assign verdict    = judge(32'(edges), 32'(tgt_q), 32'(TOL));

    vcal_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(vco_div_clk), .rise(rise)
    );

    vcal_window_meter #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_meter (
        .clk(clk), .rst(rst),
        .clear(st_q == ST_SETTLE), .run(st_q == ST_MEAS),
        .pulse(rise), .edges(edges), .last(win_last)
    );

    vcal_bisect #(.TRIM_W(TRIM_W)) u_bisect (
        .clk(clk), .rst(rst), .init(accept),
        .step(in_decide && verdict != V_BAND),
        .go_up(verdict == V_FAST),
        .cur(cur_w), .lo(lo_w), .hi(hi_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            settle_q <= '0;
            round_q  <= '0;
            tgt_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        st_q     <= ST_SETTLE;
                        settle_q <= '0;
                        round_q  <= '0;
                        tgt_q    <= tgt_full[TGT_W-1:0];
                    end
                end
                ST_SETTLE: begin
                    settle_q <= settle_q + SET_W'(1);
                    if (settle_q == SET_W'(SETTLE - 1)) st_q <= ST_MEAS;
                end
                ST_MEAS: begin
                    if (win_last) st_q <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (verdict == V_BAND || last_round) begin
                        st_q <= ST_DONE;
                    end else begin
                        st_q     <= ST_SETTLE;
                        settle_q <= '0;
                        round_q  <= round_q + RND_W'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign trim      = cur_w;
    assign open_loop = (st_q == ST_SETTLE) || (st_q == ST_MEAS) || (st_q == ST_DECIDE);
    assign done      = (st_q == ST_DONE);
endmodule

// File: rtl/vco_trim_cal_chk.sv
module vco_trim_cal_chk #(
    parameter int TRIM_W = 8,
    parameter int RND_W  = 3,
    parameter int ROUNDS = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [TRIM_W-1:0] trim,
    input logic              open_loop,
    input logic              done,
    input logic [TRIM_W-1:0] lo,
    input logic [TRIM_W-1:0] hi,
    input logic [RND_W-1:0]  round,
    input logic              in_decide
);
    localparam logic [TRIM_W-1:0] MID = {1'b0, {(TRIM_W-1){1'b1}}};

    p_ol_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(open_loop && done));

    p_start_mid_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !open_loop) |=> (open_loop && !done && trim == MID));

    p_hold_done_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(trim)));

    p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
        (open_loop && !in_decide && start) |=> open_loop);

    p_trim_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (open_loop && !in_decide) |=> $stable(trim));

    p_bounds_r8: assert property (@(posedge clk) disable iff (rst)
        (lo <= trim) && (trim <= hi));

    p_round_cap_r8: assert property (@(posedge clk) disable iff (rst)
        round < RND_W'(ROUNDS));
endmodule

bind vco_trim_cal vco_trim_cal_chk #(
    .TRIM_W(TRIM_W), .RND_W(RND_W), .ROUNDS(ROUNDS)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .trim(trim),
    .open_loop(open_loop), .done(done), .lo(lo_w), .hi(hi_w),
    .round(round_q), .in_decide(in_decide)
);

// File: tb/vco_trim_cal_test.sv
`timescale 1ns/1ps
module vco_trim_cal_test;
    localparam int RND = 24 + 1536 + 1;
    localparam int NV  = 7;
    // {div_int, div_frac, expected trim, expected rounds}
    localparam int VEC [0:NV-1][0:3] = '{
        '{19,  25, 181, 7},
        '{25, 239, 127, 1},
        '{63, 255,   0, 7},
        '{ 5,   0, 254, 7},
        '{40,   0,  13, 7},
        '{30, 128,  89, 7},
        '{21, 224, 159, 3}
    };
    localparam int SEQ [0:6] = '{127, 191, 159, 175, 183, 179, 181};

    logic       clk = 0;
    logic       rst = 1;
    logic       start = 0;
    logic       vco_div_clk = 0;
    logic [5:0] div_int = 0;
    logic [7:0] div_frac = 0;
    logic [7:0] trim;
    logic       open_loop, done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int acc = 0;
    int log_val [0:15];
    int log_cyc [0:15];
    int log_n = 0;
    bit finished = 0;

    vco_trim_cal uut (
        .clk(clk), .rst(rst), .start(start), .vco_div_clk(vco_div_clk),
        .div_int(div_int), .div_frac(div_frac),
        .trim(trim), .open_loop(open_loop), .done(done)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Oscillator model: exactly 667 - 2*trim rising edges in any 1536 cycles
    always @(negedge clk) begin
        int nxt;
        if (rst) nxt = 0;
        else     nxt = (acc + 667 - 2 * int'(trim)) % 1536;
        acc = nxt;
        vco_div_clk <= (nxt >= 768);
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string vtag(input int i);
        case (i)
            0: return "R7";
            1: return "R3";
            2: return "R5";
            3: return "R4";
            4: return "R6";
            5: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic run_cal(input int ni, input int nf, input int poke_at, output int lat);
        int t0;
        @(negedge clk);
        div_int = 6'(ni); div_frac = 8'(nf); start = 1;
        t0 = cyc + 1;
        @(negedge clk);
        start = 0;
        chk("R2", int'(open_loop), 1);
        chk("R2", int'(done), 0);
        chk("R2", int'(trim), 127);
        log_n = 1; log_val[0] = int'(trim); log_cyc[0] = t0;
        while (!done && (cyc - t0) < 20000) begin
            @(negedge clk);
            if (poke_at != 0) begin
                start = ((cyc - t0) == poke_at);
                if (start) div_int = 6'd63;
            end
            if (int'(trim) != log_val[log_n-1] && log_n < 16) begin
                log_val[log_n] = int'(trim);
                log_cyc[log_n] = cyc;
                log_n++;
            end
        end
        start = 0;
        lat = cyc - t0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lat;
        int held;
        repeat (4) @(negedge clk);
        chk("R1", int'(trim), 127);
        chk("R1", int'(done), 0);
        chk("R1", int'(open_loop), 0);
        rst = 0;
        repeat (3) @(negedge clk);
        chk("R1", int'(trim), 127);
        chk("R1", int'(open_loop), 0);

        for (int i = 0; i < NV; i++) begin
            run_cal(VEC[i][0], VEC[i][1], 0, lat);
            chk(vtag(i), int'(trim), VEC[i][2]);
            chk((i == 2 || i == 3) ? "R8" : "R11", lat, VEC[i][3] * RND);
            chk("R9", int'(done && !open_loop), 1);
            if (i == 0) begin
                chk("R7", log_n, 7);
                for (int k = 0; k < 7; k++) chk("R7", log_val[k], SEQ[k]);
                for (int k = 1; k < 7; k++) chk("R11", log_cyc[k] - log_cyc[k-1], RND);
            end
        end

        // Result held while inputs move and no start arrives
        held = int'(trim);
        div_int = 6'd7; div_frac = 8'd3;
        repeat (300) @(negedge clk);
        chk("R9", int'(trim), held);
        chk("R9", int'(done), 1);
        chk("R9", int'(open_loop), 0);

        // Second start and changed division factor during round 2
        run_cal(21, 224, 2000, lat);
        chk("R10", int'(trim), 159);
        chk("R10", lat, 3 * RND);
        chk("R3", int'(trim), 159);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule